// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two 8-bit ports, called A and B. Either port can be driven from the other, or neither can. Each port is modelled as three separate signals: an input, an output and an output enable. The pad tri-state drivers sit outside the block, which keeps it synthesizable. Each direction has a storage register. The A register holds a snapshot of the A side, and the B register holds a snapshot of the B side. Each register has its own load strobe, and no enable or select gates that strobe, so a snapshot can be taken at any time, including while both ports are isolated.

One active-low enable and one direction input choose which port, if any, is driven. Two select inputs each pick what a driven port carries. It is either the live value of the opposite port or the register that stored the opposite port. Both output values are computed on every cycle, whether or not their port is enabled. So a stored or live value is already present when the port is enabled. When a port is acting as an output, loading its own register captures the value the block drives onto that port.

Top module: `bus_xcvr_top`

## Requirements
- R1: When HAS_RESET is 1, a clock edge with rstN low clears both storage registers to zero. The reset takes priority over a load strobe in the same cycle.
- R2: While enN is high, aOe and bOe are both 0 (isolation), whatever dirToB is.
- R3: While enN is low and dirToB is 1, bOe is 1 and aOe is 0.
- R4: While enN is low and dirToB is 0, aOe is 1 and bOe is 0.
- R5: aOe and bOe are never 1 at the same time.
- R6: With storedToB at 0, bOut equals aIn in the same cycle, with no register delay, for every data pattern.
- R7: With storedToB at 1, bOut equals the A storage register.
- R8: With storedToA at 0, aOut equals bIn in the same cycle.
- R9: With storedToA at 1, aOut equals the B storage register.
- R10: While aOe is 0, a clock edge with loadA high stores aIn into the A register, whatever the state of enN, dirToB and the selects. The same rule holds for loadB, bIn and the B register while bOe is 0.
- R11: A clock edge with loadA low leaves the A register unchanged, and a clock edge with loadB low leaves the B register unchanged.
- R12: While aOe is 1, a clock edge with loadA high stores the value on aOut, not aIn. While bOe is 1, a clock edge with loadB high stores the value on bOut.
- R13: In live mode, a load in the driven direction passes the data through in the same cycle and also stores it. Example: A to B, loadA high, bOut follows aIn and the A register takes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both storage registers |
| rstN | input | 1 | Synchronous active-low clear of both registers (used when HAS_RESET is 1) |
| enN | input | 1 | Active-low output enable; high isolates both ports |
| dirToB | input | 1 | 1: drive port B; 0: drive port A |
| storedToB | input | 1 | 1: bOut carries the A register; 0: live aIn |
| storedToA | input | 1 | 1: aOut carries the B register; 0: live bIn |
| loadA | input | 1 | Load strobe for the A register |
| loadB | input | 1 | Load strobe for the B register |
| aIn | input | WIDTH | Value seen on port A |
| aOut | output | WIDTH | Value the block drives onto port A |
| aOe | output | 1 | Drive enable for port A |
| bIn | input | WIDTH | Value seen on port B |
| bOut | output | WIDTH | Value the block drives onto port B |
| bOe | output | 1 | Drive enable for port B |

## Verification
The assertions check on every cycle that at most one port is enabled (R5). They also check the register update rules: the choice of capture source between the input side and the driven side (R10, R12), and holding when there is no strobe (R11). Only the bench scenarios can show the mapping from enable and direction to each drive enable (R2 to R4), because those assertions would merely restate the decode. The same holds for the same-cycle live paths across several data patterns (R6, R8), for reading stored values back through the select inputs (R7, R9), for reset priority over a strobe (R1), and for the combined pass-and-store case (R13).

// File: rtl/bus_xcvr_pkg.sv
package bus_xcvr_pkg;

  // Strobes from the control decode to the datapath
  typedef struct packed {
    logic driveA;     // port A is an output this cycle
    logic driveB;     // port B is an output this cycle
    logic storedToA;  // aOut takes the B register instead of live bIn
    logic storedToB;  // bOut takes the A register instead of live aIn
    logic capA;       // load the A register at the next edge
    logic capB;       // load the B register at the next edge
  } xcvrStrobe_t;

endpackage

// File: rtl/bus_xcvr_ctrl.sv
module bus_xcvr_ctrl
  import bus_xcvr_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enN,
  input  logic        dirToB,
  input  logic        storedToB,
  input  logic        storedToA,
  input  logic        loadA,
  input  logic        loadB,
  output xcvrStrobe_t strobe
);

  logic enabled;

  always_comb begin
    enabled          = ~enN;
    strobe.driveB    = enabled & dirToB;
    strobe.driveA    = enabled & ~dirToB;
    strobe.storedToA = storedToA;
    strobe.storedToB = storedToB;
    // capture strobes are not qualified by the enables or selects
    strobe.capA      = loadA;
    strobe.capB      = loadB;
  end

  assert_one_driver_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.driveA, strobe.driveB}));

endmodule

// File: rtl/bus_xcvr_path.sv
module bus_xcvr_path
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  xcvrStrobe_t      strobe,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] aOut,
  output logic [WIDTH-1:0] bOut
);

  logic [WIDTH-1:0] regA;
  logic [WIDTH-1:0] regB;
  logic [WIDTH-1:0] capSrcA;
  logic [WIDTH-1:0] capSrcB;

  // Per-channel live/stored selection and capture source
  for (genvar i = 0; i < WIDTH; i++) begin : gChan
    assign bOut[i]    = strobe.storedToB ? regA[i] : aIn[i];
    assign aOut[i]    = strobe.storedToA ? regB[i] : bIn[i];
    assign capSrcA[i] = strobe.driveA ? aOut[i] : aIn[i];
    assign capSrcB[i] = strobe.driveB ? bOut[i] : bIn[i];
  end

  always_ff @(posedge clk) begin
    if (HAS_RESET && !rstN) begin
      regA <= '0;
    end else if (strobe.capA) begin
      regA <= capSrcA;
    end
  end

  always_ff @(posedge clk) begin
    if (HAS_RESET && !rstN) begin
      regB <= '0;
    end else if (strobe.capB) begin
      regB <= capSrcB;
    end
  end

  assert_capture_input_a_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capA && !strobe.driveA) |=> regA == $past(aIn));
  assert_capture_input_b_R10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capB && !strobe.driveB) |=> regB == $past(bIn));
  assert_capture_driven_a_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capA && strobe.driveA) |=> regA == $past(aOut));
  assert_capture_driven_b_R12: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capB && strobe.driveB) |=> regB == $past(bOut));
  assert_hold_a_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capA |=> $stable(regA));
  assert_hold_b_R11: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.capB |=> $stable(regB));

endmodule

// File: rtl/bus_xcvr_top.sv
module bus_xcvr_top
  import bus_xcvr_pkg::*;
#(
  parameter int WIDTH     = 8,
  parameter bit HAS_RESET = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enN,
  input  logic             dirToB,
  input  logic             storedToB,
  input  logic             storedToA,
  input  logic             loadA,
  input  logic             loadB,
  input  logic [WIDTH-1:0] aIn,
  output logic [WIDTH-1:0] aOut,
  output logic             aOe,
  input  logic [WIDTH-1:0] bIn,
  output logic [WIDTH-1:0] bOut,
  output logic             bOe
);

  xcvrStrobe_t strobe;

  bus_xcvr_ctrl i_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .enN       (enN),
    .dirToB    (dirToB),
    .storedToB (storedToB),
    .storedToA (storedToA),
    .loadA     (loadA),
    .loadB     (loadB),
    .strobe    (strobe)
  );

  bus_xcvr_path #(
    .WIDTH     (WIDTH),
    .HAS_RESET (HAS_RESET)
  ) i_path (
    .clk    (clk),
    .rstN   (rstN),
    .strobe (strobe),
    .aIn    (aIn),
    .bIn    (bIn),
    .aOut   (aOut),
    .bOut   (bOut)
  );

  assign aOe = strobe.driveA;
  assign bOe = strobe.driveB;

endmodule

// File: tb/test_bus_xcvr_top.sv
module test_bus_xcvr_top;

  localparam int W = 8;
  localparam int MAX_CYCLES = 200000;

  logic clk = 1'b0;
  logic rstN, enN, dirToB, storedToB, storedToA, loadA, loadB;
  logic [W-1:0] aIn, bIn, aOut, bOut;
  logic aOe, bOe;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bus_xcvr_top #(.WIDTH(W), .HAS_RESET(1'b1)) i_bus_xcvr_top (
    .clk(clk), .rstN(rstN), .enN(enN), .dirToB(dirToB),
    .storedToB(storedToB), .storedToA(storedToA),
    .loadA(loadA), .loadB(loadB),
    .aIn(aIn), .aOut(aOut), .aOe(aOe),
    .bIn(bIn), .bOut(bOut), .bOe(bOe)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one clock edge; return at the following falling edge
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    enN = 1'b1; dirToB = 1'b0; storedToA = 1'b0; storedToB = 1'b0;
    loadA = 1'b0; loadB = 1'b0;
  endtask

  task automatic testReset();
    rstN = 1'b0; idle();
    aIn = 8'hA5; bIn = 8'h5A; loadA = 1'b1; loadB = 1'b1;
    tick();
    tick();
    rstN = 1'b1; loadA = 1'b0; loadB = 1'b0;
    storedToA = 1'b1; storedToB = 1'b1;
    #1;
    check("R1 A register cleared", bOut, 8'h00);
    check("R1 B register cleared", aOut, 8'h00);
    check("R2 isolation after reset", {6'b0, aOe, bOe}, 8'h00);
  endtask

  task automatic testEnables();
    for (int e = 0; e < 2; e++) begin
      for (int d = 0; d < 2; d++) begin
        enN = e[0]; dirToB = d[0];
        #1;
        if (e == 1)
          check("R2 isolation", {6'b0, aOe, bOe}, 8'h00);
        else if (d == 1)
          check("R3 drive B", {6'b0, aOe, bOe}, 8'h01);
        else
          check("R4 drive A", {6'b0, aOe, bOe}, 8'h02);
        check("R5 single driver", {7'b0, aOe & bOe}, 8'h00);
      end
    end
    idle();
  endtask

  task automatic testLive();
    logic [W-1:0] pats [4] = '{8'h00, 8'hFF, 8'h96, 8'h01};
    idle();
    for (int i = 0; i < 4; i++) begin
      aIn = pats[i]; bIn = ~pats[i];
      enN = 1'b0; dirToB = 1'b1;
      #1;
      check("R6 live A to B", bOut, pats[i]);
      dirToB = 1'b0;
      #1;
      check("R8 live B to A", aOut, ~pats[i]);
      @(negedge clk);
    end
    idle();
  endtask

  task automatic testStoreIsolated();
    idle();
    aIn = 8'h3E; bIn = 8'hC1; loadA = 1'b1; loadB = 1'b1;
    tick();
    loadA = 1'b0; loadB = 1'b0;
    aIn = 8'h11; bIn = 8'h22;
    storedToB = 1'b1; storedToA = 1'b1;
    #1;
    check("R10 R7 A stored while isolated", bOut, 8'h3E);
    check("R10 R9 B stored while isolated", aOut, 8'hC1);
    // outputs switch between stored and live while isolated
    storedToB = 1'b0; storedToA = 1'b0;
    #1;
    check("R6 live while isolated", bOut, 8'h11);
    check("R8 live while isolated", aOut, 8'h22);
    idle();
  endtask

  task automatic testHold();
    idle();
    aIn = 8'h77; bIn = 8'h88;
    tick();
    tick();
    storedToB = 1'b1; storedToA = 1'b1;
    #1;
    check("R11 A register held", bOut, 8'h3E);
    check("R11 B register held", aOut, 8'hC1);
    idle();
  endtask

  task automatic testPassStore();
    idle();
    enN = 1'b0; dirToB = 1'b1; aIn = 8'h5C; loadA = 1'b1;
    #1;
    check("R13 pass through A to B", bOut, 8'h5C);
    tick();
    loadA = 1'b0; aIn = 8'h00; storedToB = 1'b1;
    #1;
    check("R13 stored while passing A to B", bOut, 8'h5C);
    idle();
    enN = 1'b0; dirToB = 1'b0; bIn = 8'hE4; loadB = 1'b1;
    #1;
    check("R13 pass through B to A", aOut, 8'hE4);
    tick();
    loadB = 1'b0; bIn = 8'h00; storedToA = 1'b1;
    #1;
    check("R13 stored while passing B to A", aOut, 8'hE4);
    idle();
  endtask

  task automatic testCaptureDriven();
    idle();
    // A is the output; its pad input disagrees with the driven value
    enN = 1'b0; dirToB = 1'b0; bIn = 8'h3C; aIn = 8'hFF; loadA = 1'b1;
    tick();
    loadA = 1'b0; enN = 1'b1; storedToB = 1'b1;
    #1;
    check("R12 A register takes driven aOut", bOut, 8'h3C);
    // B is the output and shows the A register; capture into B
    idle();
    enN = 1'b0; dirToB = 1'b1; storedToB = 1'b1; bIn = 8'h00; loadB = 1'b1;
    tick();
    loadB = 1'b0; enN = 1'b1; storedToA = 1'b1;
    #1;
    check("R12 B register takes driven bOut", aOut, 8'h3C);
    idle();
  endtask

  initial begin
    aIn = '0; bIn = '0; rstN = 1'b0; idle();
    @(negedge clk);
    testReset();
    testEnables();
    testLive();
    testStoreIsolated();
    testHold();
    testPassStore();
    testCaptureDriven();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (MAX_CYCLES) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule